// File: doc/BRIEF.md
# Serial EEPROM Sequential Read Master

This block is a two-wire bus master that fetches a run of bytes from a serial EEPROM. It assumes the memory's internal address pointer was loaded by an earlier write phase. A request carries three things: the addressing mode, the three upper page bits and the number of bytes minus one. On accepting it, the block issues a start condition and sends a control byte with the read bit set. It then checks that the memory acknowledges, clocks in the data bytes and answers each one. It closes with a stop condition.

Clock and data are open-drain. The block drives an enable that pulls the line low, and it releases the line otherwise. The bus clock runs at four quarter-periods per bit, and each quarter lasts `QTR_DIV` system clocks. Received bytes appear on a data output with a one-cycle strobe. A missing acknowledge on the control byte ends the transfer early and raises a sticky timeout flag.

Top module: `eeprom_seq_reader`

## Requirements
- R1: The control byte is sent MSB first. Its bits 7:4 are 1010 and its bit 0 is 1 (read).
- R2: With `req_wide`=0 (one-byte addressing), control bits 3:1 carry `req_page[2:0]`, so bit 3 holds memory address bit 10 and bit 1 holds bit 8.
- R3: With `req_wide`=1 (two-byte addressing), control bits 3:1 are 000 whatever `req_page` holds.
- R4: Exactly `req_len_m1`+1 bytes are received, each MSB first. Each is presented on `rd_data` with `rd_valid` high for one cycle, in arrival order.
- R5: The master acknowledges (SDA low) every data byte except the last. It leaves the last one unacknowledged (SDA released) and then issues a stop.
- R6: If SDA is high during the acknowledge slot after the control byte, no data byte is read, a stop is still generated, both lines end released and `timeout` is set.
- R7: `timeout` stays set until the next accepted request, which clears it.
- R8: SDA changes only while SCL is low. The two exceptions are the start (SDA falls with SCL high) and the stop (SDA rises with SCL high). Each transfer holds exactly one start and one stop.
- R9: `busy` is high from the cycle after a request is accepted until the transfer ends. A `req_valid` seen while busy is ignored.
- R10: Out of reset and while idle, `scl_oe` and `sda_oe` are low (lines released), and `busy`, `done`, `rd_valid` and `timeout` are low.
- R11: `done` is a one-cycle pulse in the cycle where `busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a transfer (accepted only when idle) |
| req_wide | input | 1 | 1 = two-byte addressing mode, 0 = one-byte |
| req_page | input | 3 | Memory address bits 10:8 for one-byte mode |
| req_len_m1 | input | LEN_W | Number of bytes to read minus one |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | 8 | Last received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| timeout | output | 1 | Sticky: control byte was not acknowledged |

## Verification
A behavioural EEPROM on the bench decodes start, stop, control bits and master acknowledges straight from the two lines. It returns a byte sequence that comes from a per-transfer seed. The main sweep covers both addressing modes, every page value and lengths of one to four bytes. This separates the select-field mapping (page bits against zeros) and shows where the last-byte no-acknowledge falls. A 16-byte and a 9-byte read exercise the remaining-count wrap and long acknowledge chains. Refused acknowledges in both modes cover the abort path and the sticky flag, and a request injected mid-transfer shows that busy requests are ignored.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CTL,
    ST_CACK,
    ST_DATA,
    ST_MACK,
    ST_STOP
  } eerd_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // What the pins should do in a given state and quarter.
  typedef struct packed {
    logic scl_low;
    logic sda_hold;
    logic sda_low;
  } pin_plan_t;

  // Control byte: device code, select field, read bit.
  function automatic logic [7:0] ctl_byte(input logic wide, input logic [2:0] page);
    logic [2:0] sel;
    sel = wide ? 3'b000 : page;
    return {DEV_CODE, sel, 1'b1};
  endfunction

  // Quarter 0 and 1 keep SCL low, 2 and 3 release it; SDA is only
  // updated in quarter 1 of a bit slot, so it moves while SCL is low.
  function automatic pin_plan_t pin_plan(input eerd_state_e st, input logic [1:0] ph,
                                         input logic bit_val, input logic more);
    pin_plan_t p;
    p.scl_low  = 1'b0;
    p.sda_hold = 1'b0;
    p.sda_low  = 1'b0;
    case (st)
      ST_IDLE: begin
        p.scl_low = 1'b0;
        p.sda_low = 1'b0;
      end
      ST_START: begin
        p.scl_low = ph[1];
        p.sda_low = (ph != 2'd0);
      end
      ST_CTL: begin
        p.scl_low  = ~ph[1];
        p.sda_hold = (ph == 2'd0);
        p.sda_low  = ~bit_val;
      end
      ST_MACK: begin
        p.scl_low  = ~ph[1];
        p.sda_hold = (ph == 2'd0);
        p.sda_low  = more;
      end
      ST_STOP: begin
        p.scl_low  = ~ph[1];
        p.sda_hold = (ph == 2'd0);
        p.sda_low  = (ph != 2'd3);
      end
      default: begin
        p.scl_low  = ~ph[1];
        p.sda_hold = (ph == 2'd0);
        p.sda_low  = 1'b0;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/eerd_tick_div.sv
module eerd_tick_div #(
  parameter int unsigned QTR_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  generate
    if (QTR_DIV <= 1) begin : g_every
      assign tick = ~clr;
    end else begin : g_count
      localparam int unsigned CW = $clog2(QTR_DIV);
      localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = (cnt_q == LAST);

      // R8
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/eerd_rx_byte.sv
module eerd_rx_byte #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic              sda_bit,
  input  logic              emit,
  output logic [BYTE_W-1:0] data,
  output logic              valid
);

  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (sample) sh_q <= {sh_q[BYTE_W-2:0], sda_bit};
      if (emit) data_q <= sh_q;
      valid_q <= emit;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
  import eerd_pkg::*;
#(
  parameter int unsigned QTR_DIV     = 8,
  parameter int unsigned LEN_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wide,
  input  logic [2:0]       req_page,
  input  logic [LEN_W-1:0] req_len_m1,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             timeout
);

  localparam int unsigned SYN_N = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  eerd_state_e      st, st_n;
  logic [1:0]       ph, ph_n;
  logic [2:0]       bitn, bit_n;
  logic [LEN_W-1:0] left, left_n;
  logic [7:0]       ctl_q;
  logic             ack_q;
  logic             timeout_q, done_q;
  logic             scl_oe_q, sda_oe_q;
  pin_plan_t        plan;

  // Named internal events.
  logic tick, accept;
  logic ev_smp_ack, ev_smp_dat, ev_byte, ev_abort, ev_fin;
  logic sda_s;

  // Input synchroniser for the sensed data line.
  logic [SYN_N-1:0] sync_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= sda_in;
      for (int i = 1; i < SYN_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end
  assign sda_s = sync_q[SYN_N-1];

  assign accept = (st == ST_IDLE) && req_valid;

  eerd_tick_div #(.QTR_DIV(QTR_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .tick (tick)
  );

  eerd_rx_byte #(.BYTE_W(8)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (ev_smp_dat),
    .sda_bit(sda_s),
    .emit   (ev_byte),
    .data   (rd_data),
    .valid  (rd_valid)
  );

  always_comb begin
    st_n       = st;
    ph_n       = ph;
    bit_n      = bitn;
    left_n     = left;
    ev_smp_ack = 1'b0;
    ev_smp_dat = 1'b0;
    ev_byte    = 1'b0;
    ev_abort   = 1'b0;
    ev_fin     = 1'b0;
    if (st == ST_IDLE) begin
      if (req_valid) begin
        st_n = ST_START;
        ph_n = 2'd0;
      end
    end else if (tick) begin
      ph_n = ph + 2'd1;
      if (ph == 2'd2) begin
        ev_smp_ack = (st == ST_CACK);
        ev_smp_dat = (st == ST_DATA);
      end
      if (ph == 2'd3) begin
        case (st)
          ST_START: begin
            st_n  = ST_CTL;
            bit_n = 3'd7;
          end
          ST_CTL: begin
            if (bitn == 3'd0) st_n = ST_CACK;
            else bit_n = bitn - 3'd1;
          end
          ST_CACK: begin
            if (!ack_q) begin
              st_n  = ST_DATA;
              bit_n = 3'd7;
            end else begin
              st_n     = ST_STOP;
              ev_abort = 1'b1;
            end
          end
          ST_DATA: begin
            if (bitn == 3'd0) begin
              st_n    = ST_MACK;
              ev_byte = 1'b1;
            end else begin
              bit_n = bitn - 3'd1;
            end
          end
          ST_MACK: begin
            if (left == '0) begin
              st_n = ST_STOP;
            end else begin
              left_n = left - 1'b1;
              st_n   = ST_DATA;
              bit_n  = 3'd7;
            end
          end
          ST_STOP: begin
            st_n   = ST_IDLE;
            ev_fin = 1'b1;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
    plan = pin_plan(st_n, ph_n, ctl_q[bit_n], left_n != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= 2'd0;
      bitn      <= 3'd0;
      left      <= '0;
      ctl_q     <= '0;
      ack_q     <= 1'b1;
      timeout_q <= 1'b0;
      done_q    <= 1'b0;
      scl_oe_q  <= 1'b0;
      sda_oe_q  <= 1'b0;
    end else begin
      st     <= st_n;
      ph     <= ph_n;
      bitn   <= bit_n;
      left   <= left_n;
      done_q <= ev_fin;
      if (accept) begin
        ctl_q     <= ctl_byte(req_wide, req_page);
        left      <= req_len_m1;
        timeout_q <= 1'b0;
      end else if (ev_abort) begin
        timeout_q <= 1'b1;
      end
      if (ev_smp_ack) ack_q <= sda_s;
      scl_oe_q <= plan.scl_low;
      if (!plan.sda_hold) sda_oe_q <= plan.sda_low;
    end
  end

  assign scl_oe  = scl_oe_q;
  assign sda_oe  = sda_oe_q;
  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign timeout = timeout_q;

  // R8
  sda_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(ev_abort));

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctl_q));

  // R6
  abort_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !rd_valid);

endmodule

// File: tb/eeprom_seq_reader_tb.sv
`timescale 1ns/1ps
module eeprom_seq_reader_tb;

  localparam int unsigned QD = 2;
  localparam int unsigned LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_wide = 1'b0;
  logic [2:0]    req_page = 3'd0;
  logic [LW-1:0] req_len_m1 = '0;
  logic          scl_oe, sda_oe, sda_in, rd_valid, busy, done, timeout;
  logic [7:0]    rd_data;
  logic          s_drv = 1'b0;

  assign sda_in = ~(sda_oe | s_drv);

  eeprom_seq_reader #(.QTR_DIV(QD), .LEN_W(LW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wide(req_wide),
    .req_page(req_page), .req_len_m1(req_len_m1), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .timeout(timeout)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int s, input int i);
    return 8'((s * 29 + i * 83 + 5) & 255);
  endfunction

  // Behavioural EEPROM and line monitor.
  bit         ack_en = 1'b1;
  int         seed = 0;
  int         starts = 0, stops = 0, macks = 0, mnacks = 0;
  logic [7:0] ctl_seen = 8'd0;
  int         fr = 0, cnt = 0, idx = 0;
  logic [7:0] cur = 8'd0;
  bit         last_ack = 1'b0;

  initial begin : slave_model
    logic scl_p, sda_p, scl_n, sda_n;
    scl_p = 1'b1;
    sda_p = 1'b1;
    forever begin
      @(negedge clk);
      scl_n = ~scl_oe;
      sda_n = ~(sda_oe | s_drv);
      if (scl_p && scl_n && sda_p && !sda_n) begin
        starts++;
        fr = 1; cnt = 0; idx = 0; cur = pat(seed, 0);
      end else if (scl_p && scl_n && !sda_p && sda_n) begin
        stops++;
        fr = 0; s_drv = 1'b0;
      end else if (!scl_p && scl_n) begin
        if (fr != 0) begin
          cnt++;
          if (fr == 1 && cnt <= 8) ctl_seen = {ctl_seen[6:0], sda_n};
          if (fr == 2 && cnt == 9) begin
            last_ack = ~sda_n;
            if (sda_n) mnacks++; else macks++;
          end
        end
      end else if (scl_p && !scl_n) begin
        if (fr == 1) begin
          if (cnt == 8) s_drv = ack_en;
          else if (cnt == 9) begin
            s_drv = 1'b0;
            if (ack_en) begin fr = 2; cnt = 0; s_drv = ~cur[7]; end
            else fr = 0;
          end
        end else if (fr == 2) begin
          if (cnt >= 1 && cnt <= 7) s_drv = ~cur[7 - cnt];
          else if (cnt == 8) s_drv = 1'b0;
          else if (cnt == 9) begin
            if (last_ack) begin
              idx++; cur = pat(seed, idx); cnt = 0; s_drv = ~cur[7];
            end else begin
              fr = 0; s_drv = 1'b0;
            end
          end
        end
      end
      scl_p = scl_n;
      sda_p = ~(sda_oe | s_drv);
    end
  end

  logic [7:0] got [0:15];
  int nrx = 0;

  initial begin : rx_monitor
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (nrx < 16) got[nrx] = rd_data;
        nrx++;
      end
    end
  end

  task automatic xfer(input bit wide, input int page, input int n, input bit aen, input bit poke);
    int cyc;
    bit low_seen;
    logic [7:0] exp_ctl;
    seed = seed + 1;
    ack_en = aen;
    starts = 0; stops = 0; macks = 0; mnacks = 0; nrx = 0; ctl_seen = 8'd0;
    @(negedge clk);
    req_valid = 1'b1; req_wide = wide; req_page = 3'(page); req_len_m1 = LW'(n - 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", int'(busy), 1);
    chk("R7 timeout cleared by new request", int'(timeout), 0);
    cyc = 0;
    low_seen = 1'b0;
    while (1) begin
      if (poke && cyc == 30) begin
        req_valid = 1'b1; req_wide = ~wide; req_page = ~3'(page); req_len_m1 = '0;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (done) break;
      if (!busy) low_seen = 1'b1;
      if (cyc >= 8000) break;
    end
    req_valid = 1'b0;
    chk("R11 done seen before watchdog", int'(done), 1);
    chk("R11 busy low with done", int'(busy), 0);
    chk("R9 busy held until end", int'(low_seen), 0);
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
    exp_ctl = 8'hA1 | (wide ? 8'h00 : 8'(page << 1));
    chk("R1 device code", int'(ctl_seen[7:4]), 10);
    chk("R1 read bit", int'(ctl_seen[0]), 1);
    if (wide) chk("R3 select bits zero", int'(ctl_seen[3:1]), int'(exp_ctl[3:1]));
    else chk("R2 select bits = page", int'(ctl_seen[3:1]), int'(exp_ctl[3:1]));
    chk("R8 one start", starts, 1);
    chk("R8 one stop", stops, 1);
    chk("R6 timeout state", int'(timeout), aen ? 0 : 1);
    if (aen) begin
      chk("R4 byte count", nrx, n);
      for (int i = 0; i < n && i < 16; i++) chk("R4 byte value", int'(got[i]), int'(pat(seed, i)));
      chk("R5 master acks", macks, n - 1);
      chk("R5 final no-ack", mnacks, 1);
    end else begin
      chk("R6 no data on abort", nrx, 0);
      chk("R6 no master answer", macks + mnacks, 0);
      chk("R6 lines released", int'({scl_oe, sda_oe}), 0);
    end
    if (poke) begin
      repeat (60) @(negedge clk);
      chk("R9 busy request ignored: starts", starts, 1);
      chk("R9 busy request ignored: idle", int'(busy), 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 scl released in reset", int'(scl_oe), 0);
    chk("R10 sda released in reset", int'(sda_oe), 0);
    chk("R10 busy low in reset", int'(busy), 0);
    chk("R10 timeout low in reset", int'(timeout), 0);
    chk("R10 valid/done low in reset", int'({rd_valid, done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 idle lines released", int'({scl_oe, sda_oe, busy}), 0);

    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 8; p++)
        for (int n = 1; n <= 4; n++)
          xfer(w[0], p, n, 1'b1, 1'b0);

    xfer(1'b0, 5, 16, 1'b1, 1'b0);
    xfer(1'b1, 3, 9, 1'b1, 1'b0);

    xfer(1'b0, 6, 3, 1'b0, 1'b0);
    repeat (50) @(negedge clk);
    chk("R7 timeout sticky while idle", int'(timeout), 1);
    xfer(1'b1, 0, 2, 1'b0, 1'b0);
    xfer(1'b0, 2, 2, 1'b1, 1'b0);

    xfer(1'b0, 4, 3, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule